// File: doc/BRIEF.md
# I2C Target Setup/Configuration Register Writer

This block is the write side of an I2C target for a converter-style peripheral. It samples the bus lines with a fast system clock and finds START, repeated START and STOP. It takes in a 7-bit address followed by a direction bit, and acknowledges the address only when the address matches and the transfer is a write. After that, every data byte is acknowledged. The top bit of each byte chooses where the byte goes, so there is no register pointer.

A byte with its top bit set is a setup byte. It updates a 3-bit reference select, a clock-source flag and a polarity flag. If its bit 1 is zero, it also returns the configuration register to all zeros. A byte with its top bit clear is written in full into the 8-bit configuration register. A separate flag records that the high-speed master code was seen, and the next STOP clears it.

Top module: `i2c_setup_writer`

## Requirements
- R1: A synchronous active-high `rst` brings `refSel`, `extClock`, `bipolar`, `cfgReg` and `hsMode` to zero.
- R2: After a START, the address byte is taken MSB first on rising SCL edges. If bits 7..1 equal `DEV_ADDR` and bit 0 is 0 (write), the block pulls SDA low (`sdaPullLow` = 1) during the ninth SCL clock.
- R3: If the address does not match, or bit 0 is 1 (read), the block gives no acknowledge. It then ignores every further byte (no acknowledge, no register change) until the next START or STOP.
- R4: A data byte with bit 7 = 1 sets `refSel` = bits 6..4, `extClock` = bit 3 (1 = external) and `bipolar` = bit 2 (1 = bipolar). Bit 0 has no effect.
- R5: A data byte with bit 7 = 0 is stored in full into `cfgReg`, and the setup fields stay unchanged.
- R6: Every data byte after an acknowledged address is acknowledged. One or two bytes, in either order, produce the same register state as writing them one after another.
- R7: A setup byte with bit 1 = 0 also clears `cfgReg` to zero. With bit 1 = 1, `cfgReg` keeps its value.
- R8: A repeated START ends the current write and begins a new address phase.
- R9: An address-phase byte of the form 00001xxx sets `hsMode` and is not acknowledged. A repeated START keeps `hsMode`, and a STOP clears it.
- R10: `sdaPullLow` is 0 at all times other than an acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| sclIn | input | 1 | I2C clock line level |
| sdaIn | input | 1 | I2C data line level |
| sdaPullLow | output | 1 | 1 = drive SDA low (open-drain enable) |
| refSel | output | 3 | Reference select field of the setup register |
| extClock | output | 1 | Clock source, 1 = external |
| bipolar | output | 1 | Polarity mode, 1 = bipolar |
| cfgReg | output | 8 | Configuration register contents |
| hsMode | output | 1 | High-speed mode flag |

## Verification
A wrong bit counter or a wrong phase state shows up first on `sdaPullLow`. The acknowledge then lands on the wrong clock, or is missing, within the same byte. A wrong routing or reset decision shows on the register outputs a few system cycles after the eighth SCL fall of the byte. The bench compares those outputs with its model on every idle clock. A flag that is lost or kept too long on `hsMode` shows within a few cycles of the STOP or repeated START.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_BITS = 8;
  localparam logic [4:0] HS_CODE_TOP = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK, ST_SKIP
  } phase_t;

  typedef struct packed {
    logic       wrSetup;
    logic       wrCfg;
    logic       hsSet;
    logic       hsClr;
    logic [7:0] byteVal;
  } wrStrobe_t;
endpackage

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h33,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output wrStrobe_t  strobe
);
  localparam int TOP   = SYNC_STAGES - 1;
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic startDet, stopDet, sclRise, sclFall, byteDone, addrHit, hsCode;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_BITS-1:0] shiftReg;
  phase_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync[TOP];
      sdaPrev <= sdaSync[TOP];
    end
  end

  assign sclNow   = sclSync[TOP];
  assign sdaNow   = sdaSync[TOP];
  assign startDet = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopDet  = sclNow && sclPrev && !sdaPrev && sdaNow;
  assign sclRise  = sclNow && !sclPrev;
  assign sclFall  = !sclNow && sclPrev;
  assign byteDone = sclFall && (bitCnt == CNT_W'(BYTE_BITS)) && !startDet && !stopDet;
  assign addrHit  = (shiftReg[7:1] == DEV_ADDR) && !shiftReg[0];
  assign hsCode   = (shiftReg[7:3] == HS_CODE_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      shiftReg   <= '0;
      sdaPullLow <= 1'b0;
    end else if (startDet) begin
      state      <= ST_ADDR;
      bitCnt     <= '0;
      sdaPullLow <= 1'b0;
    end else if (stopDet) begin
      state      <= ST_IDLE;
      sdaPullLow <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_DATA: begin
          if (sclRise && bitCnt < CNT_W'(BYTE_BITS)) begin
            shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaNow};
            bitCnt   <= bitCnt + 1'b1;
          end else if (byteDone) begin
            bitCnt <= '0;
            if (state == ST_ADDR && !addrHit) begin
              state <= ST_SKIP;
            end else begin
              state      <= (state == ST_ADDR) ? ST_ADDR_ACK : ST_DATA_ACK;
              sdaPullLow <= 1'b1;
            end
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (sclFall) begin
            sdaPullLow <= 1'b0;
            state      <= ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.wrSetup = byteDone && (state == ST_DATA) && shiftReg[7];
    strobe.wrCfg   = byteDone && (state == ST_DATA) && !shiftReg[7];
    strobe.hsSet   = byteDone && (state == ST_ADDR) && hsCode;
    strobe.hsClr   = stopDet;
    strobe.byteVal = shiftReg;
  end

  // R10
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdaPullLow) |-> $past(sclFall));
  // R10
  pull_only_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    sdaPullLow |-> (state == ST_ADDR_ACK || state == ST_DATA_ACK));
  // R3
  skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sdaPullLow && !strobe.wrSetup && !strobe.wrCfg);
  // R5
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobe.wrSetup && strobe.wrCfg));
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs
  import i2cw_pkg::*;
#(
  parameter int REF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  wrStrobe_t        strobe,
  output logic [REF_W-1:0] refSel,
  output logic             extClock,
  output logic             bipolar,
  output logic [7:0]       cfgReg,
  output logic             hsMode
);
  localparam int REF_LSB = 4;

  always_ff @(posedge clk) begin
    if (rst) begin
      refSel   <= '0;
      extClock <= 1'b0;
      bipolar  <= 1'b0;
      cfgReg   <= '0;
      hsMode   <= 1'b0;
    end else begin
      if (strobe.wrSetup) begin
        refSel   <= strobe.byteVal[REF_LSB +: REF_W];
        extClock <= strobe.byteVal[3];
        bipolar  <= strobe.byteVal[2];
        if (!strobe.byteVal[1]) cfgReg <= '0;
      end else if (strobe.wrCfg) begin
        cfgReg <= strobe.byteVal;
      end
      if (strobe.hsClr)      hsMode <= 1'b0;
      else if (strobe.hsSet) hsMode <= 1'b1;
    end
  end

  // R7
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrSetup && !strobe.byteVal[1]) |=> (cfgReg == 8'h00));
  // R5
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.wrCfg |=> (cfgReg == $past(strobe.byteVal)));
  // R4
  setup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrSetup |=> $stable(refSel) && $stable(extClock) && $stable(bipolar));
  // R9
  hs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.hsClr |=> !hsMode);
endmodule

// File: rtl/i2c_setup_writer.sv
module i2c_setup_writer
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h33,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic [2:0] refSel,
  output logic       extClock,
  output logic       bipolar,
  output logic [7:0] cfgReg,
  output logic       hsMode
);
  wrStrobe_t strobe;

  i2cw_ctrl #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaPullLow(sdaPullLow), .strobe(strobe)
  );

  i2cw_regs #(.REF_W(3)) uRegs (
    .clk(clk), .rst(rst), .strobe(strobe),
    .refSel(refSel), .extClock(extClock), .bipolar(bipolar),
    .cfgReg(cfgReg), .hsMode(hsMode)
  );
endmodule

// File: tb/sim_i2c_setup_writer.sv
`timescale 1ns/1ps
module sim_i2c_setup_writer;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam logic [6:0] ADDR = 7'h33;

  logic clk = 0, rst = 1, sclM = 1, sdaM = 1;
  logic sdaPullLow, extClock, bipolar, hsMode;
  logic [2:0] refSel;
  logic [7:0] cfgReg;
  wire sdaLine = sdaM & ~sdaPullLow;

  int checks = 0, failures = 0;
  bit compareEn = 0, done = 0;
  logic [2:0] expRef = 0;
  logic expExt = 0, expBip = 0, expHs = 0;
  logic [7:0] expCfg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_setup_writer #(.DEV_ADDR(ADDR)) u0 (
    .clk(clk), .rst(rst), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .refSel(refSel), .extClock(extClock),
    .bipolar(bipolar), .cfgReg(cfgReg), .hsMode(hsMode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (!rst && compareEn) begin
      check(refSel == expRef, "R4 refSel", refSel, expRef);
      check(extClock == expExt, "R4 extClock", extClock, expExt);
      check(bipolar == expBip, "R4 bipolar", bipolar, expBip);
      check(cfgReg == expCfg, "R5 R7 cfgReg", cfgReg, expCfg);
      check(hsMode == expHs, "R9 hsMode", hsMode, expHs);
      check(sdaPullLow == 1'b0, "R10 idle release", sdaPullLow, 0);
    end
  end

  task automatic waitH(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    compareEn = 0;
    sdaM = 1; waitH(H); sclM = 1; waitH(H);
    sdaM = 0; waitH(H); sclM = 0; waitH(H);
  endtask

  task automatic busStop();
    compareEn = 0;
    sdaM = 0; waitH(H); sclM = 1; waitH(H);
    sdaM = 1; waitH(H);
    expHs = 0;
    compareEn = 1;
    waitH(H);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    compareEn = 0;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitH(H);
      sclM = 1; waitH(H/2);
      check(sdaPullLow == 1'b0, "R10 bit release", sdaPullLow, 0);
      waitH(H/2);
      sclM = 0;
    end
    sdaM = 1; waitH(H);
    sclM = 1; waitH(H/2);
    check(sdaPullLow == expAck, req, sdaPullLow, expAck);
    waitH(H/2);
    sclM = 0; waitH(H);
  endtask

  task automatic model(input logic [7:0] b);
    if (b[7]) begin
      expRef = b[6:4]; expExt = b[3]; expBip = b[2];
      if (!b[1]) expCfg = 8'h00;
    end else begin
      expCfg = b;
    end
  endtask

  task automatic wrData(input logic [7:0] b);
    sendByte(b, 1'b1, "R6 data ack");
    model(b);
    compareEn = 1;
    waitH(H);
  endtask

  task automatic addrWrite();
    sendByte({ADDR, 1'b0}, 1'b1, "R2 address ack");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    waitH(2);
    // R1: reset state
    check(refSel == 0 && extClock == 0 && bipolar == 0, "R1 setup reset", {refSel, extClock, bipolar}, 0);
    check(cfgReg == 0, "R1 cfg reset", cfgReg, 0);
    check(hsMode == 0 && sdaPullLow == 0, "R1 flags reset", {hsMode, sdaPullLow}, 0);
    compareEn = 1;
    waitH(H);

    // R4 R5 R6: setup then config; bit1=1 keeps cfg
    busStart(); addrWrite(); wrData(8'hA6); wrData(8'h5A); busStop();
    check(cfgReg == 8'h5A && refSel == 3'b010 && bipolar == 1, "R6 setup-then-config", {refSel, cfgReg}, {3'b010, 8'h5A});

    // R6 R7: config then setup with bit1=1 and bit0=1 (ignored)
    busStart(); addrWrite(); wrData(8'h3C); wrData(8'hDB); busStop();
    check(cfgReg == 8'h3C && refSel == 3'b101 && extClock == 1, "R7 cfg kept", {refSel, cfgReg}, {3'b101, 8'h3C});

    // R7: setup bit1=0 clears cfg; R8: repeated START then a new write
    busStart(); addrWrite(); wrData(8'h98);
    check(cfgReg == 8'h00, "R7 cfg cleared", cfgReg, 0);
    busStart(); addrWrite(); wrData(8'h11); busStop();
    check(cfgReg == 8'h11, "R8 write after repeated start", cfgReg, 8'h11);

    // R3: wrong address, then a data byte that must be ignored
    busStart(); sendByte({7'h22, 1'b0}, 1'b0, "R3 no ack on mismatch");
    sendByte(8'h7F, 1'b0, "R3 ignored byte no ack"); compareEn = 1; busStop();
    check(cfgReg == 8'h11, "R3 cfg unchanged", cfgReg, 8'h11);

    // R3: read bit, ignored byte, R8: repeated START to a valid write
    busStart(); sendByte({ADDR, 1'b1}, 1'b0, "R3 no ack on read");
    sendByte(8'h80, 1'b0, "R3 ignored after read"); compareEn = 1; waitH(H);
    check(refSel == 3'b001, "R3 setup unchanged", refSel, 3'b001);
    busStart(); addrWrite(); wrData(8'h05); busStop();

    // R9: high-speed code sets flag, kept over repeated START, cleared by STOP
    busStart(); sendByte(8'h09, 1'b0, "R9 hs code no ack");
    expHs = 1; compareEn = 1; waitH(H);
    check(hsMode == 1, "R9 hs set", hsMode, 1);
    busStart(); addrWrite(); wrData(8'hF2);
    check(hsMode == 1, "R9 hs kept over repeated start", hsMode, 1);
    busStop();
    check(hsMode == 0, "R9 hs cleared by stop", hsMode, 0);

    // R7 R4: setup 0x81 clears cfg, bit0 ignored
    busStart(); addrWrite(); wrData(8'h81); busStop();
    check(cfgReg == 0 && refSel == 0 && extClock == 0 && bipolar == 0, "R7 R4 setup 0x81",
          {refSel, extClock, bipolar, cfgReg}, 0);

    // R1: reset mid-state
    busStart(); addrWrite(); wrData(8'h6E); busStop();
    compareEn = 0; rst = 1; waitH(2); rst = 0; waitH(1);
    check(cfgReg == 0 && hsMode == 0, "R1 reset clears", cfgReg, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule